// File: doc/BRIEF.md
# Programmable Fully Parallel FIR Filter

This block is a direct-form FIR filter in which every tap is computed in the same clock. The tap weights are not fixed when the chip is built. A host loads them at run time through a small write port that has a data word, an address, a write strobe and a "load complete" strobe. Samples and coefficients are signed Q1.15 words. The filter produces one output for each clock on which its clock enable is high.

The writes land in a shadow bank. The load-complete strobe then moves the whole shadow bank into the active bank in a single edge, so each output uses either the old weights or the new weights, never a mix of the two. The sample history in the delay line is never touched by a reload, and filtering continues on the existing history with the new weights.

Build parameters select:
- a symmetric variant, in which mirrored taps share one stored weight;
- whether the symmetric pre-add is widened before the sum or wraps in the sample width;
- an optional input register and an optional output register.

Top module: `progFir`

## Requirements
- R1: The output is the sum of sample×coefficient products (Q2.30), rounded to nearest with ties toward +∞ (add 2^14, then shift right arithmetically by 15). It is then saturated to the range [-32768, 32767].
- R2: On each enabled edge the accepted sample enters tap 0, and every tap k takes the previous value of tap k-1.
- R3: An active-high `rst` clears, without waiting for a clock edge, the delay line, the input and output registers, and both coefficient banks. `sampleOut` reads 0 while `rst` is high.
- R4: While `clkEn` is low, no register changes. Coefficient writes and load-complete strobes presented in those cycles are ignored.
- R5: A coefficient write (`coefWrEn` high, enabled edge) stores `coefData` at `coefAddr` in the shadow bank only. The output does not use it until the next load-complete strobe.
- R6: `coefWrDone` high on an enabled edge copies the whole shadow bank into the active bank on that edge, and leaves the delay line untouched. A write in the same cycle is not part of that copy.
- R7: With SYMMETRIC=1, coefficient address k (0 ≤ k < ceil(TAPS/2)) weights both tap k and tap TAPS-1-k. The two samples are added before the multiply. For odd TAPS, the centre tap is multiplied alone.
- R8: With CAST_BEFORE_SUM=1, the symmetric pre-add is exact, in 17 bits. With CAST_BEFORE_SUM=0, it wraps to 16-bit two's complement before the multiply.
- R9: With both IN_REG and OUT_REG at 0, `sampleOut` reflects the sample taken at the same enabled edge. IN_REG=1 and OUT_REG=1 each add one enabled edge of latency.
- R10: Writes to an address at or above the coefficient count (TAPS, or ceil(TAPS/2) when symmetric) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| clkEn | input | 1 | Clock enable for every register |
| sampleIn | input | DATA_W (16) | Input sample, signed Q1.15 |
| coefData | input | DATA_W (16) | Coefficient word, signed Q1.15 |
| coefAddr | input | ADDR_W | Shadow-bank write address |
| coefWrEn | input | 1 | Coefficient write strobe |
| coefWrDone | input | 1 | Load complete: shadow bank to active bank |
| sampleOut | output | DATA_W (16) | Filtered sample, signed Q1.15 |

## Verification
The bench builds two instances side by side on the same sample stream.

| Instance | TAPS | SYMMETRIC | CAST_BEFORE_SUM | IN_REG | OUT_REG |
|---|---|---|---|---|---|
| `dut` | 7 | 1 | 0 | 1 | 1 |
| `dutPlain` | 5 | 0 | 1 | 0 | 0 |

`dut` brings within reach the mirrored-pair addressing, the odd centre tap, the wrapping pre-add on full-scale samples and two edges of pipeline latency. `dutPlain` covers the plain per-tap weights, zero latency and out-of-range addresses that are not a power of two.

The same stimulus runs once under each of two coefficient sets. The second set is loaded while samples are streaming and while the enable is low. Full-scale inputs drive both saturation limits.

// File: rtl/firPkg.sv
`timescale 1ns/1ps
// Shared types for the programmable FIR filter.
package firPkg;
  // Strobes from control to datapath, one clock wide.
  typedef struct packed {
    logic shift;  // advance the input stage, delay line and output stage
    logic load;   // write one shadow coefficient
    logic swap;   // copy the shadow bank into the active bank
  } firStrobes_t;
endpackage

// File: rtl/firCtrl.sv
`timescale 1ns/1ps
// Qualifies the host strobes with the clock enable and the address range.
module firCtrl
  import firPkg::*;
#(
  parameter int COEF_N = 4,
  parameter int ADDR_W = 2
) (
  input  logic              clkEn,
  input  logic              coefWrEn,
  input  logic              coefWrDone,
  input  logic [ADDR_W-1:0] coefAddr,
  output firStrobes_t       strb
);
  logic addrOk;

  always_comb begin
    addrOk     = (int'(coefAddr) < COEF_N);            // R10
    strb.shift = clkEn;                                 // R4
    strb.load  = clkEn & coefWrEn & addrOk;             // R5
    strb.swap  = clkEn & coefWrDone;                    // R6
  end
endmodule

// File: rtl/firTapLine.sv
`timescale 1ns/1ps
// Optional input register followed by the sample delay line.
module firTapLine #(
  parameter int TAPS   = 7,
  parameter int DATA_W = 16,
  parameter int IN_REG = 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         shift,
  input  logic [DATA_W-1:0]            din,
  output logic [TAPS-1:0][DATA_W-1:0]  tapVec
);
  logic [DATA_W-1:0] lineIn;

  generate
    if (IN_REG != 0) begin : g_inReg
      logic [DATA_W-1:0] inQ;
      always_ff @(posedge clk or posedge rst) begin
        if (rst)        inQ <= '0;
        else if (shift) inQ <= din;
      end
      assign lineIn = inQ;
    end else begin : g_noInReg
      assign lineIn = din;
    end
  endgenerate

  // R2: new sample at tap 0, older samples move one place along.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      tapVec <= '0;
    end else if (shift) begin
      tapVec[0] <= lineIn;
      for (int k = 1; k < TAPS; k++) tapVec[k] <= tapVec[k-1];
    end
  end
endmodule

// File: rtl/firCoefBank.sv
`timescale 1ns/1ps
// Shadow and active coefficient banks.
module firCoefBank #(
  parameter int COEF_N = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load,
  input  logic                          swap,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             data,
  output logic [COEF_N-1:0][DATA_W-1:0] coefActive
);
  logic [COEF_N-1:0][DATA_W-1:0] coefShadow;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      coefShadow <= '0;
      coefActive <= '0;
    end else begin
      // R6: the copy sees the shadow contents from before this edge.
      if (swap) coefActive <= coefShadow;
      for (int k = 0; k < COEF_N; k++) begin
        if (load && (addr == ADDR_W'(k))) coefShadow[k] <= data;
      end
    end
  end
endmodule

// File: rtl/firMacTree.sv
`timescale 1ns/1ps
// Pre-add, multiply, sum, round, saturate and optional output register.
module firMacTree #(
  parameter int TAPS            = 7,
  parameter int DATA_W          = 16,
  parameter int COEF_N          = 4,
  parameter int SYMMETRIC       = 1,
  parameter int CAST_BEFORE_SUM = 0,
  parameter int OUT_REG         = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          advance,
  input  logic [TAPS-1:0][DATA_W-1:0]   tapVec,
  input  logic [COEF_N-1:0][DATA_W-1:0] coefActive,
  output logic [DATA_W-1:0]             sampleOut
);
  localparam int FRAC_W = DATA_W - 1;
  localparam int PRE_W  = DATA_W + 1;
  localparam int PROD_W = PRE_W + DATA_W;
  localparam int ACC_W  = PROD_W + $clog2(COEF_N + 1) + 1;
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< FRAC_W) - 64'sd1);
  localparam logic signed [ACC_W-1:0] MINV = ~MAXV;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'sd1 <<< (FRAC_W - 1));

  logic signed [PROD_W-1:0] prod [COEF_N];
  logic signed [ACC_W-1:0]  acc, rnd, shifted;
  logic [DATA_W-1:0]        yComb;

  generate
    for (genvar k = 0; k < COEF_N; k++) begin : g_term
      if ((SYMMETRIC != 0) && (k < TAPS / 2)) begin : g_pair
        // R7: mirrored samples share one weight.
        logic signed [DATA_W-1:0] ta, tb;
        logic signed [PRE_W-1:0]  pre;
        assign ta = tapVec[k];
        assign tb = tapVec[TAPS-1-k];
        if (CAST_BEFORE_SUM != 0) begin : g_wide
          assign pre = PRE_W'(ta) + PRE_W'(tb);         // R8 exact
        end else begin : g_native
          logic signed [DATA_W-1:0] nat;
          assign nat = ta + tb;                         // R8 wraps
          assign pre = PRE_W'(nat);
        end
        assign prod[k] = PROD_W'(pre) * PROD_W'($signed(coefActive[k]));
      end else begin : g_single
        // One tap, or the centre tap of an odd symmetric filter.
        logic signed [DATA_W-1:0] ta;
        assign ta = tapVec[k];
        assign prod[k] = PROD_W'(ta) * PROD_W'($signed(coefActive[k]));
      end
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int k = 0; k < COEF_N; k++) acc = acc + ACC_W'(prod[k]);
    rnd     = acc + HALF;                               // R1 round to nearest
    shifted = rnd >>> FRAC_W;
    if (shifted > MAXV)      yComb = MAXV[DATA_W-1:0];
    else if (shifted < MINV) yComb = MINV[DATA_W-1:0];
    else                     yComb = shifted[DATA_W-1:0];
  end

  generate
    if (OUT_REG != 0) begin : g_outReg
      logic [DATA_W-1:0] outQ;
      always_ff @(posedge clk or posedge rst) begin
        if (rst)          outQ <= '0;
        else if (advance) outQ <= yComb;
      end
      assign sampleOut = outQ;
    end else begin : g_noOutReg
      assign sampleOut = yComb;
    end
  endgenerate
endmodule

// File: rtl/progFir.sv
`timescale 1ns/1ps
// Programmable fully parallel FIR filter (top).
module progFir
  import firPkg::*;
#(
  parameter int TAPS            = 7,
  parameter int DATA_W          = 16,
  parameter int SYMMETRIC       = 1,
  parameter int CAST_BEFORE_SUM = 0,
  parameter int IN_REG          = 1,
  parameter int OUT_REG         = 1,
  localparam int COEF_N = (SYMMETRIC != 0) ? (TAPS + 1) / 2 : TAPS,
  localparam int ADDR_W = (COEF_N > 1) ? $clog2(COEF_N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkEn,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic [DATA_W-1:0] coefData,
  input  logic [ADDR_W-1:0] coefAddr,
  input  logic              coefWrEn,
  input  logic              coefWrDone,
  output logic [DATA_W-1:0] sampleOut
);
  firStrobes_t                   strb;
  logic [TAPS-1:0][DATA_W-1:0]   tapVec;
  logic [COEF_N-1:0][DATA_W-1:0] coefActive;

  firCtrl #(.COEF_N(COEF_N), .ADDR_W(ADDR_W)) u_ctrl (
    .clkEn(clkEn), .coefWrEn(coefWrEn), .coefWrDone(coefWrDone),
    .coefAddr(coefAddr), .strb(strb)
  );

  firTapLine #(.TAPS(TAPS), .DATA_W(DATA_W), .IN_REG(IN_REG)) u_line (
    .clk(clk), .rst(rst), .shift(strb.shift), .din(sampleIn), .tapVec(tapVec)
  );

  firCoefBank #(.COEF_N(COEF_N), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst), .load(strb.load), .swap(strb.swap),
    .addr(coefAddr), .data(coefData), .coefActive(coefActive)
  );

  firMacTree #(
    .TAPS(TAPS), .DATA_W(DATA_W), .COEF_N(COEF_N), .SYMMETRIC(SYMMETRIC),
    .CAST_BEFORE_SUM(CAST_BEFORE_SUM), .OUT_REG(OUT_REG)
  ) u_mac (
    .clk(clk), .rst(rst), .advance(strb.shift), .tapVec(tapVec),
    .coefActive(coefActive), .sampleOut(sampleOut)
  );
endmodule

// File: rtl/progFirChk.sv
`timescale 1ns/1ps
// Temporal checks on the programmable FIR filter, bound into its top.
module progFirChk
  import firPkg::*;
#(
  parameter int TAPS   = 7,
  parameter int COEF_N = 4,
  parameter int DATA_W = 16
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          clkEn,
  input logic [DATA_W-1:0]             sampleOut,
  input firStrobes_t                   strb,
  input logic [TAPS-1:0][DATA_W-1:0]   tapVec,
  input logic [COEF_N-1:0][DATA_W-1:0] coefActive
);
  p_reset_zero_r3: assert property (@(posedge clk) rst |-> sampleOut == '0);

  p_gate_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !clkEn |=> ($stable(sampleOut) && $stable(tapVec) && $stable(coefActive)));

  p_active_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !strb.swap |=> $stable(coefActive));

  generate
    if (TAPS >= 2) begin : g_shiftChk
      p_shift_r2: assert property (@(posedge clk) disable iff (rst)
        strb.shift |=> tapVec[1] == $past(tapVec[0]));
    end
  endgenerate
endmodule

bind progFir progFirChk #(.TAPS(TAPS), .COEF_N(COEF_N), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .clkEn(clkEn), .sampleOut(sampleOut),
  .strb(strb), .tapVec(tapVec), .coefActive(coefActive)
);

// File: tb/tb_progFir.sv
`timescale 1ns/1ps
module tb_progFir;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, clkEn, wrEnA, wrEnB, wrDone;
  logic signed [15:0] sampleIn, coefData, outA, outB;
  logic [1:0] addrA;
  logic [2:0] addrB;

  progFir #(.TAPS(7), .SYMMETRIC(1), .CAST_BEFORE_SUM(0), .IN_REG(1), .OUT_REG(1)) dut (
    .clk(clk), .rst(rst), .clkEn(clkEn), .sampleIn(sampleIn), .coefData(coefData),
    .coefAddr(addrA), .coefWrEn(wrEnA), .coefWrDone(wrDone), .sampleOut(outA));

  progFir #(.TAPS(5), .SYMMETRIC(0), .CAST_BEFORE_SUM(1), .IN_REG(0), .OUT_REG(0)) dutPlain (
    .clk(clk), .rst(rst), .clkEn(clkEn), .sampleIn(sampleIn), .coefData(coefData),
    .coefAddr(addrB), .coefWrEn(wrEnB), .coefWrDone(wrDone), .sampleOut(outB));

  // Behavioural reference state.
  int hA[8], hB[8], shA[8], acA[8], shB[8], acB[8];
  int inRegA, outRegA, expA, expB;
  int nVec = 0, nBad = 0;
  int unsigned seed;

  function automatic int wrap16(int v);
    return ((v + 32768) & 65535) - 32768;
  endfunction

  function automatic int evalFir(int h[8], int c[8], int taps, bit sym, bit cast);
    longint acc = 0;
    int pre;
    if (sym) begin
      for (int k = 0; k < taps / 2; k++) begin
        pre = h[k] + h[taps-1-k];
        if (!cast) pre = wrap16(pre);
        acc += longint'(pre) * longint'(c[k]);
      end
      if (taps % 2 == 1) acc += longint'(h[taps/2]) * longint'(c[taps/2]);
    end else begin
      for (int k = 0; k < taps; k++) acc += longint'(h[k]) * longint'(c[k]);
    end
    acc = (acc + 16384) >>> 15;
    if (acc > 32767) return 32767;
    if (acc < -32768) return -32768;
    return int'(acc);
  endfunction

  function automatic int nextSample();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed[31:16]) - 32768;
  endfunction

  task automatic clearModel();
    for (int k = 0; k < 8; k++) begin
      hA[k] = 0; hB[k] = 0; shA[k] = 0; acA[k] = 0; shB[k] = 0; acB[k] = 0;
    end
    inRegA = 0; outRegA = 0; expA = 0; expB = 0;
  endtask

  task automatic check(string tag, string who, logic signed [15:0] act, int e);
    nVec++;
    if ($isunknown(act) || int'(act) != e) begin
      nBad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, who, act, e);
    end
  endtask

  // One clock: drive at the falling edge, update the model at the rising edge,
  // compare at the next falling edge.
  task automatic step(bit en, int x, bit wA, bit wB, int addr, int data, bit done, string tag);
    clkEn = en; sampleIn = 16'(x); wrEnA = wA; wrEnB = wB;
    addrA = 2'(addr); addrB = 3'(addr); coefData = 16'(data); wrDone = done;
    @(posedge clk);
    if (en) begin
      int yb;
      yb = evalFir(hA, acA, 7, 1'b1, 1'b0);
      for (int k = 6; k > 0; k--) hA[k] = hA[k-1];
      hA[0] = inRegA;
      inRegA = x;
      for (int k = 4; k > 0; k--) hB[k] = hB[k-1];
      hB[0] = x;
      if (done) begin acA = shA; acB = shB; end
      if (wA && addr < 4) shA[addr] = data;
      if (wB && addr < 5) shB[addr] = data;
      outRegA = yb;
    end
    expA = outRegA;
    expB = evalFir(hB, acB, 5, 1'b0, 1'b1);
    @(negedge clk);
    check(tag, "dut", outA, expA);
    check(tag, "dutPlain", outB, expB);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
  endtask

  int set1A[4] = '{328, -3277, 9830, 16384};
  int set1B[5] = '{1000, -2000, 12000, 8000, -500};
  int set2A[4] = '{32767, 32767, -20000, 5000};
  int set2B[5] = '{32767, 32767, 32767, 32767, 32767};

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: got timeout expected run completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b0; clkEn = 1'b0; sampleIn = '0; coefData = '0;
    addrA = '0; addrB = '0; wrEnA = 1'b0; wrEnB = 1'b0; wrDone = 1'b0;
    #1 rst = 1'b1;
    clearModel();
    repeat (3) @(negedge clk);
    check("R3 reset", "dut", outA, 0);
    check("R3 reset", "dutPlain", outB, 0);
    rst = 1'b0;

    // First coefficient set, shadow only, then the swap.
    for (int k = 0; k < 4; k++) step(1, 0, 1, 0, k, set1A[k], 0, "R5 load");
    for (int k = 0; k < 5; k++) step(1, 0, 0, 1, k, set1B[k], 0, "R5 load");
    step(1, 0, 0, 0, 0, 0, 1, "R6 swap");

    // Impulse: shift order and latency.
    step(1, 16384, 0, 0, 0, 0, 0, "R2 R9 impulse");
    for (int i = 0; i < 9; i++) step(1, 0, 0, 0, 0, 0, 0, "R2 R9 impulse");

    // Two passes of the same stream under two coefficient sets.
    for (int pass = 0; pass < 2; pass++) begin
      seed = 32'h1234_5678;
      for (int i = 0; i < 20; i++) step(1, nextSample(), 0, 0, 0, 0, 0, "R7 R8 stream");
      for (int i = 0; i < 6; i++) step(1, 32767, 0, 0, 0, 0, 0, "R1 R8 full scale");
      for (int i = 0; i < 6; i++) step(1, -32768, 0, 0, 0, 0, 0, "R1 R8 full scale");
      if (pass == 0) begin
        // Second set written into the shadows while samples stream on.
        for (int k = 0; k < 4; k++) step(1, nextSample(), 1, 0, k, set2A[k], 0, "R5 shadow");
        for (int k = 0; k < 5; k++) step(1, nextSample(), 0, 1, k, set2B[k], 0, "R5 shadow");
        // Writes and a swap with the enable low must be lost.
        step(0, nextSample(), 1, 1, 0, -7, 0, "R4 gated");
        step(0, nextSample(), 0, 0, 0, 0, 1, "R4 gated");
        step(0, nextSample(), 1, 1, 1, 11, 1, "R4 gated");
        step(1, nextSample(), 0, 0, 0, 0, 0, "R4 gated");
        // Out-of-range addresses on the five-tap instance.
        for (int a = 5; a < 8; a++) step(1, nextSample(), 0, 1, a, -30000, 0, "R10 range");
        step(1, nextSample(), 0, 0, 0, 0, 1, "R6 swap");
        for (int i = 0; i < 8; i++) step(1, nextSample(), 0, 0, 0, 0, 0, "R6 history");
      end
    end

    // Reset in mid-run acts without a clock edge.
    @(negedge clk);
    rst = 1'b1;
    #1;
    check("R3 async", "dut", outA, 0);
    check("R3 async", "dutPlain", outB, 0);
    clearModel();
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) step(1, 20000, 0, 0, 0, 0, 0, "R3 cleared banks");

    summary();
    $finish;
  end
endmodule